// File: doc/BRIEF.md
# Watchdog Reset and Sleep Supervisor

This block is the digital half of a processor supply supervisor. It sits next to a linear regulator and decides two things every clock: whether the regulator output stays switched on, and whether the processor it feeds is held in reset. It watches a software watchdog strobe from the processor, a digitised undervoltage flag from the output comparator, a power-good flag that says the output has come up, and an enable request from the system.

Reset is held while the output is powering up and for a power-on delay after that. It is also held when a real undervoltage outlasts a filter window. When the watchdog goes quiet, reset becomes a square pulse train, so that a hung processor keeps getting restarted. If the enable request is low and the watchdog stops, the regulator output is switched off. A processor can therefore end its own supply by stopping its strobe once enable has dropped. All delays come from one timing unit, expressed as a count of system clocks: the power-on delay is 47.5 units, each pulse phase is 1 unit and the watchdog timeout is 13 units.

Top module: `wdog_supervisor`

## Requirements
- R1: While the synchronous reset `rst_n` is low, `cpu_rst_n` is low and `reg_en` is high.
- R2: After `pwr_good` is high with no other reset cause, `cpu_rst_n` stays low for the power-on delay of 47.5 × `UNIT_CYC` clocks (rounded down) and then goes high.
- R3: A low `pwr_good` drives `cpu_rst_n` low on the next clock and restarts the power-on delay.
- R4: An undervoltage (`uv_flag` = 1) lasting fewer than `UV_FILT_CYC` clocks has no effect on `cpu_rst_n`.
- R5: An undervoltage lasting `UV_FILT_CYC` clocks drives `cpu_rst_n` low. Reset then stays low until the flag clears and a full power-on delay has passed.
- R6: Only falling edges of `wd_strobe` count. A falling edge at least once every 13 × `UNIT_CYC` clocks keeps the watchdog valid. A strobe held high or held low makes it invalid after that timeout.
- R7: With the watchdog invalid and `en_req` high, `cpu_rst_n` toggles with low and high phases of `UNIT_CYC` clocks each, starting low.
- R8: A falling edge on `wd_strobe` during the pulse train makes the watchdog valid again and stops the train with `cpu_rst_n` high.
- R9: With `en_req` high, `reg_en` is high.
- R10: With `en_req` low and the watchdog valid, `reg_en` stays high and `cpu_rst_n` stays high.
- R11: With `en_req` low and the watchdog invalid, the block sleeps: `reg_en` is low and `cpu_rst_n` is low.
- R12: Sleep ends only when `en_req` goes high. `reg_en` then returns high and a full power-on delay is run before `cpu_rst_n` rises.
- R13: At the end of each power-on delay the watchdog counts as valid, and the processor has one full timeout window to produce its first falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the base of every delay |
| rst_n | input | 1 | Synchronous active-low block reset |
| wd_strobe | input | 1 | Watchdog strobe from the processor (asynchronous) |
| en_req | input | 1 | Enable request (asynchronous) |
| uv_flag | input | 1 | 1 while the output is below its regulation limit |
| pwr_good | input | 1 | 1 once the output has risen into regulation |
| reg_en | output | 1 | Regulator output enable, 1 = on |
| cpu_rst_n | output | 1 | Active-low processor reset |

## Verification
A stuck or corrupted watchdog interval timer shows at `cpu_rst_n` as a pulse train that starts while strobes are still arriving, or as a train that never starts. In either case the error is visible within one 13-unit timeout of the strobe pattern changing. A wrong power-on counter shifts the rising edge of `cpu_rst_n` away from its 47.5-unit mark after reset, undervoltage or wake. A sleep flag in the wrong state shows within three clocks of `en_req` settling, as a `reg_en` level that contradicts the enable and watchdog combination. The bench samples each output in the middle of its stable windows and measures pulse-train period and run length directly.

// File: rtl/wdsup_pkg.sv
// Package: shared timing arithmetic for the watchdog supervisor.
// Assumes every delay is an integer count of system clocks derived from a
// single timing unit.
package wdsup_pkg;

    // Power-on delay in clocks: 47.5 timing units.
    function automatic int por_cycles(input int unit_cyc);
        return (unit_cyc * 95) / 2;
    endfunction

    // Watchdog timeout in clocks: 13 timing units.
    function automatic int wd_cycles(input int unit_cyc);
        return unit_cyc * 13;
    endfunction

endpackage

// File: rtl/wdsup_sync.sv
// Module: two-flop synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; no bus coherence is implied.
module wdsup_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta_q;
            logic stab_q;
            // Two register stages per bit to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= d_in[i];
                    stab_q <= meta_q;
                end
            end
            assign d_out[i] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/wdsup_wdmon.sv
// Module: watchdog interval monitor. Detects falling edges of the
// synchronised strobe and times the gap between them.
// Assumes `arm` is low during any power-on delay; while disarmed the watchdog
// is reported valid and the timer is held at zero (start-up grace window).
module wdsup_wdmon #(
    parameter int TMO_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_s,
    input  logic arm,
    output logic wd_ok
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TMO_CYC - 1);

    logic          prev_q;
    logic          fall;
    logic [TW-1:0] tmr_q;

    // Remember last strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe_s;
    end

    assign fall = prev_q & ~strobe_s;

    // Interval timer: restart on each falling edge, expire after the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            tmr_q <= '0;
            wd_ok <= 1'b1;
        end else if (fall) begin
            tmr_q <= '0;
            wd_ok <= 1'b1;
        end else if (tmr_q == T_LAST) begin
            wd_ok <= 1'b0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdsup_uvfilt.sv
// Module: undervoltage qualification filter. Reports a fault only after the
// raw flag has been high for FILT_CYC consecutive clocks.
// Assumes the flag is already synchronous to clk.
module wdsup_uvfilt #(
    parameter int FILT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_raw,
    output logic uv_q
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] C_FULL = CW'(FILT_CYC);

    logic [CW-1:0] cnt_q;

    // Count consecutive undervoltage clocks, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !uv_raw) cnt_q <= '0;
        else if (cnt_q != C_FULL) cnt_q <= cnt_q + 1'b1;
    end

    assign uv_q = (cnt_q == C_FULL);
endmodule

// File: rtl/wdsup_rstgen.sv
// Module: processor reset generator. Runs the power-on delay and, once it has
// elapsed, produces a square pulse train while the watchdog is invalid.
// Assumes `hold` gathers every condition that forces reset and restarts the delay.
module wdsup_rstgen #(
    parameter int POR_CYC   = 47,
    parameter int PULSE_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic wd_ok,
    output logic por_done,
    output logic cpu_rst_n
);
    localparam int PW = $clog2(POR_CYC + 1);
    localparam int QW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [PW-1:0] P_FULL = PW'(POR_CYC);
    localparam logic [QW-1:0] Q_LAST = QW'(PULSE_CYC - 1);

    logic [PW-1:0] por_q;
    logic [QW-1:0] ph_cnt_q;
    logic          ph_hi_q;
    logic          train;

    assign por_done = (por_q == P_FULL);
    assign train    = por_done & ~wd_ok & ~hold;

    // Power-on delay counter, cleared by any hold cause.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)       por_q <= '0;
        else if (por_q != P_FULL) por_q <= por_q + 1'b1;
    end

    // Pulse-train phase timer: low phase first, each phase PULSE_CYC clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || !train) begin
            ph_cnt_q <= '0;
            ph_hi_q  <= 1'b0;
        end else if (ph_cnt_q == Q_LAST) begin
            ph_cnt_q <= '0;
            ph_hi_q  <= ~ph_hi_q;
        end else begin
            ph_cnt_q <= ph_cnt_q + 1'b1;
        end
    end

    // Registered reset output.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_rst_n <= 1'b0;
        else        cpu_rst_n <= ~hold & por_done & (wd_ok | (train & ph_hi_q));
    end
endmodule

// File: rtl/wdog_supervisor.sv
// Module: top of the watchdog reset and sleep supervisor. Synchronises the
// strobe and enable request, combines watchdog, undervoltage and power-good
// state into the processor reset, and owns the sleep decision for the regulator.
// Assumes uv_flag and pwr_good are already synchronous to clk.
module wdog_supervisor
    import wdsup_pkg::*;
#(
    parameter int UNIT_CYC    = 1000,
    parameter int UV_FILT_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_strobe,
    input  logic en_req,
    input  logic uv_flag,
    input  logic pwr_good,
    output logic reg_en,
    output logic cpu_rst_n
);
    localparam int POR_CYC = por_cycles(UNIT_CYC);
    localparam int TMO_CYC = wd_cycles(UNIT_CYC);

    logic [1:0] async_in;
    logic [1:0] sync_out;
    logic       strobe_s;
    logic       en_s;
    logic       wd_ok;
    logic       uv_q;
    logic       por_done;
    logic       sleep_q;
    logic       hold;

    assign async_in = {en_req, wd_strobe};
    assign strobe_s = sync_out[0];
    assign en_s     = sync_out[1];

    wdsup_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (async_in),
        .d_out (sync_out)
    );

    wdsup_wdmon #(.TMO_CYC(TMO_CYC)) u_wdmon (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_s (strobe_s),
        .arm      (por_done),
        .wd_ok    (wd_ok)
    );

    wdsup_uvfilt #(.FILT_CYC(UV_FILT_CYC)) u_uvfilt (
        .clk    (clk),
        .rst_n  (rst_n),
        .uv_raw (uv_flag),
        .uv_q   (uv_q)
    );

    assign hold = ~pwr_good | uv_q | sleep_q;

    wdsup_rstgen #(.POR_CYC(POR_CYC), .PULSE_CYC(UNIT_CYC)) u_rstgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .wd_ok     (wd_ok),
        .por_done  (por_done),
        .cpu_rst_n (cpu_rst_n)
    );

    // Sleep state: enter on enable low with a starved watchdog, leave on enable high.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sleep_q <= 1'b0;
        else if (sleep_q && en_s)        sleep_q <= 1'b0;
        else if (!sleep_q && !en_s && !wd_ok) sleep_q <= 1'b1;
    end

    assign reg_en = ~sleep_q;
endmodule

// File: rtl/wdsup_chk.sv
// Module: property checker for wdog_supervisor, attached by bind.
// Assumes visibility of the synchronised enable, the qualified undervoltage
// flag and the power-on completion signal.
module wdsup_chk (
    input logic clk,
    input logic rst_n,
    input logic en_s,
    input logic uv_q,
    input logic por_done,
    input logic pwr_good,
    input logic reg_en,
    input logic cpu_rst_n
);
    // R9 / R12: a high synchronised enable keeps or brings the output on.
    assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_s |=> reg_en);

    // R5: a qualified undervoltage forces reset on the next clock.
    assert_uv_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        uv_q |=> !cpu_rst_n);

    // R3: a missing power-good forces reset on the next clock.
    assert_pg_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !cpu_rst_n);

    // R11: with the output off, the processor is held in reset.
    assert_sleep_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> !cpu_rst_n);

    // R2: reset can only be released once the power-on delay is complete.
    assert_por_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> por_done);
endmodule

bind wdog_supervisor wdsup_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (en_s),
    .uv_q      (uv_q),
    .por_done  (por_done),
    .pwr_good  (pwr_good),
    .reg_en    (reg_en),
    .cpu_rst_n (cpu_rst_n)
);

// File: tb/tb_wdog_supervisor.sv
// Bench: scoreboard style. The driver queues expected output levels; a
// monitor on the falling clock edge pops and compares them.
module tb_wdog_supervisor;
    localparam int UNIT = 20;
    localparam int UVF  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wd_strobe;
    logic en_req = 1'b1;
    logic uv_flag = 1'b0;
    logic pwr_good = 1'b1;
    logic reg_en;
    logic cpu_rst_n;

    logic strobe_on = 1'b0;
    logic hold_lvl  = 1'b0;
    int   scyc = 0;

    int nchk = 0;
    int nfail = 0;

    typedef struct {
        string tag;
        bit    sel_en;
        bit    exp;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    wdog_supervisor #(.UNIT_CYC(UNIT), .UV_FILT_CYC(UVF)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_strobe (wd_strobe),
        .en_req    (en_req),
        .uv_flag   (uv_flag),
        .pwr_good  (pwr_good),
        .reg_en    (reg_en),
        .cpu_rst_n (cpu_rst_n)
    );

    // Strobe source: 100-clock period (falling edge every 100) or a held level.
    initial begin
        wd_strobe = 1'b0;
        forever begin
            @(posedge clk);
            scyc = scyc + 1;
            wd_strobe = strobe_on ? ((scyc % 100) < 50) : hold_lvl;
        end
    end

    function automatic void report(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endfunction

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            report(it.tag, it.sel_en ? int'(reg_en) : int'(cpu_rst_n), int'(it.exp));
        end
    end

    task automatic expect_lvl(string tag, bit sel_en, bit exp);
        item_t it;
        it.tag = tag; it.sel_en = sel_en; it.exp = exp;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
    endtask

    // Hold reset high for n clocks, checked every clock.
    task automatic expect_steady(string tag, int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            expect_lvl(tag, 1'b0, 1'b1);
        end
    endtask

    // Measure a 400-clock stretch of the pulse train.
    task automatic pulse_check(string tag);
        int rises = 0;
        int run = 0;
        int maxrun = 0;
        logic prev;
        @(negedge clk);
        prev = cpu_rst_n;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (cpu_rst_n == prev) run++;
            else begin
                if (run + 1 > maxrun) maxrun = run + 1;
                run = 0;
                if (cpu_rst_n) rises++;
            end
            prev = cpu_rst_n;
        end
        report({tag, " rises in 400"}, (rises >= 9 && rises <= 11) ? 1 : 0, 1);
        report({tag, " phase length"}, maxrun, UNIT);
    endtask

    initial begin
        wait_cyc(5);
        expect_lvl("R1 reset cpu_rst_n", 1'b0, 1'b0);
        expect_lvl("R1 reset reg_en", 1'b1, 1'b1);
        rst_n = 1'b1;

        wait_cyc(900);
        expect_lvl("R2 still in power-on delay", 1'b0, 1'b0);
        expect_lvl("R9 enable high keeps output on", 1'b1, 1'b1);
        wait_cyc(100);
        expect_lvl("R2 released after delay", 1'b0, 1'b1);
        wait_cyc(100);
        expect_lvl("R13 grace window without strobe", 1'b0, 1'b1);

        strobe_on = 1'b1;
        for (int k = 0; k < 6; k++) begin
            wait_cyc(100);
            expect_lvl("R6 regular falling edges keep reset high", 1'b0, 1'b1);
        end

        // Short dip below the filter time.
        uv_flag = 1'b1; wait_cyc(20); uv_flag = 1'b0;
        expect_steady("R4 short dip ignored", 100);

        // Long undervoltage.
        uv_flag = 1'b1;
        wait_cyc(60);
        expect_lvl("R5 qualified undervoltage resets", 1'b0, 1'b0);
        wait_cyc(40);
        uv_flag = 1'b0;
        wait_cyc(500);
        expect_lvl("R5 reset held through power-on delay", 1'b0, 1'b0);
        wait_cyc(500);
        expect_lvl("R5 reset released after delay", 1'b0, 1'b1);

        // Strobe held high: starvation and pulse train.
        hold_lvl = 1'b1; strobe_on = 1'b0;
        wait_cyc(400);
        pulse_check("R7 train, strobe held high (R6)");
        strobe_on = 1'b1;
        wait_cyc(150);
        expect_steady("R8 edge ends pulse train", 200);

        // Strobe held low.
        hold_lvl = 1'b0; strobe_on = 1'b0;
        wait_cyc(400);
        pulse_check("R7 train, strobe held low (R6)");
        strobe_on = 1'b1;
        wait_cyc(200);
        expect_lvl("R8 recovery after low hold", 1'b0, 1'b1);

        // Enable low with a live watchdog.
        en_req = 1'b0;
        wait_cyc(500);
        expect_lvl("R10 output stays on", 1'b1, 1'b1);
        expect_lvl("R10 reset stays high", 1'b0, 1'b1);

        // Enable low and watchdog stops: sleep.
        hold_lvl = 1'b0; strobe_on = 1'b0;
        wait_cyc(450);
        expect_lvl("R11 sleep output off", 1'b1, 1'b0);
        expect_lvl("R11 sleep reset low", 1'b0, 1'b0);

        // Wake.
        en_req = 1'b1;
        wait_cyc(10);
        expect_lvl("R12 wake output on", 1'b1, 1'b1);
        expect_lvl("R12 wake reset low", 1'b0, 1'b0);
        strobe_on = 1'b1;
        wait_cyc(490);
        expect_lvl("R12 power-on delay after wake", 1'b0, 1'b0);
        wait_cyc(500);
        expect_lvl("R12 reset released after wake", 1'b0, 1'b1);

        // Power-good drop.
        @(posedge clk);
        pwr_good = 1'b0;
        @(posedge clk);
        @(posedge clk);
        expect_lvl("R3 power-good low resets", 1'b0, 1'b0);
        pwr_good = 1'b1;
        wait_cyc(1000);
        expect_lvl("R3 reset released after power-good returns", 1'b0, 1'b1);

        wait_cyc(3);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule